// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives a single DRAM bank. A client hands it one access at a time (row, column, read or write) over a valid/ready handshake, and the block turns each access into the shortest legal series of ACTIVATE, READ, WRITE and PRECHARGE commands. It remembers which row is open and holds one down-counter per spacing rule, so every command waits exactly as long as the slowest rule that applies to it and no longer.

A parameter selects the page policy. In open-page mode a request to the open row goes straight to READ or WRITE, a request to another row first closes the bank, and a row left untouched for `IDLE_WIN` cycles with no request waiting is closed speculatively (a value of 0 disables this timeout). In closed-page mode every access is followed by a PRECHARGE. Each READ also produces a one-cycle read-data-valid pulse a fixed CAS latency later.

Top module: `dram_bank_seq`

## Requirements
- R1: A READ or WRITE command is never output fewer than `TRCD` cycles after the ACTIVATE that opened its row, and the first access after an ACTIVATE comes exactly `TRCD` cycles after it unless another rule holds it longer.
- R2: `rd_valid` is high for one cycle exactly `TCL` cycles after each cycle in which a READ command is output, and at no other time.
- R3: An ACTIVATE is output no sooner than `TRP` cycles after the previous PRECHARGE, and exactly `TRP` cycles after it when a request was already waiting.
- R4: A PRECHARGE is output no sooner than `TRAS` cycles after the ACTIVATE of the row it closes.
- R5: After a WRITE, a PRECHARGE waits at least `TWR` cycles and a READ waits at least `TWTR` cycles; each wait is exact when it is the binding rule.
- R6: In open-page mode a request to the open row issues its READ or WRITE as the next command, without ACTIVATE, two cycles after acceptance unless a spacing rule holds it.
- R7: In open-page mode a request to a different row issues PRECHARGE (row output = old row), then ACTIVATE of the new row, then the access; a waiting row-miss precharge takes precedence over the idle timeout.
- R8: In open-page mode with no request pending, the open row is precharged in the first cycle that is at least `IDLE_WIN` cycles after the last access and also satisfies R4 and R5; a request accepted earlier keeps the row open.
- R9: In closed-page mode every READ or WRITE is followed by a PRECHARGE at the earliest legal cycle, and a second request to the same row activates it again.
- R10: `req_ready` is low from the cycle after a request is accepted until the cycle its READ or WRITE is output; at most one command is output per cycle; `cmd_code` is 0 idle, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, and `cmd_valid` is high exactly when the code is non-zero; `cmd_col` is meaningful for READ and WRITE only.
- R11: After reset `req_ready` is high, no command or read-valid pulse is output, no row is open and all timers are expired, so the first request issues ACTIVATE two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 3 | Command code (see R10) |
| cmd_row | output | ROW_W | Row for ACTIVATE, READ, WRITE, PRECHARGE |
| cmd_col | output | COL_W | Column for READ and WRITE |
| rd_valid | output | 1 | Read data valid, CAS latency after READ |

## Verification
The awkward situation is a request that arrives in the very cycle the idle timeout fires: depending on a single cycle, the row is either reused or closed and reopened, and both outcomes must be timed to the cycle. The bench reaches it by sweeping the gap between two requests across the whole idle window, with reads and writes, same and different rows, under both policies, while an arithmetic model derives every command's cycle as the maximum of the spacing rules that apply to it and checks for the timeout race explicitly.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic {
    PAGE_OPEN   = 1'b0,
    PAGE_CLOSED = 1'b1
  } page_e;

  // Timer slots
  localparam int TI_RCD  = 0;
  localparam int TI_RP   = 1;
  localparam int TI_RAS  = 2;
  localparam int TI_WR   = 3;
  localparam int TI_WTR  = 4;
  localparam int TI_IDLE = 5;
  localparam int NTMR    = 6;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dbs_dcnt.sv
// Down-counter: loaded with (spacing - 1) in the cycle a command is chosen,
// reads zero once the spacing has elapsed.
module dbs_dcnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? value : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dbs_rdpipe.sv
// Delays the READ strobe by DEPTH cycles.
module dbs_rdpipe #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_out,
  output logic rd_valid
);

  generate
    if (DEPTH == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= 1'b0;
        else        stage_q <= rd_out;
      end
      assign rd_valid = stage_q;
    end else begin : g_chain
      logic [DEPTH-1:0] chain_q;
      logic [DEPTH-1:0] chain_d;
      always_comb chain_d = {chain_q[DEPTH-2:0], rd_out};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end
      assign rd_valid = chain_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/dbs_sched.sv
// Chooses at most one command per cycle from the pending request, the row
// state and the expired flags of the spacing timers.
module dbs_sched
  import dbs_pkg::*;
#(
  parameter int    ROW_W   = 14,
  parameter page_e POLICY  = PAGE_OPEN,
  parameter bit    IDLE_EN = 1'b1
) (
  input  logic             pend,
  input  logic [ROW_W-1:0] pend_row,
  input  logic             pend_wr,
  input  logic             row_open,
  input  logic             row_used,
  input  logic [ROW_W-1:0] open_row,
  input  logic [NTMR-1:0]  tz,
  output cmd_e             nxt
);

  logic same_row;
  logic hit;
  logic pre_ok;
  logic rd_ok;
  logic wr_ok;
  logic auto_close;

  always_comb begin
    same_row = row_open && (open_row == pend_row);
    // closed-page reuses a row only for the access that opened it
    hit      = same_row && ((POLICY == PAGE_OPEN) || !row_used);
    pre_ok   = tz[TI_RAS] && tz[TI_WR];
    rd_ok    = tz[TI_RCD] && tz[TI_WTR];
    wr_ok    = tz[TI_RCD];
    if (POLICY == PAGE_CLOSED) auto_close = row_used;
    else                       auto_close = IDLE_EN && row_used && tz[TI_IDLE];
  end

  always_comb begin
    nxt = CMD_NOP;
    if (pend) begin
      if (hit) begin
        if (pend_wr) begin
          if (wr_ok) nxt = CMD_WR;
        end else if (rd_ok) begin
          nxt = CMD_RD;
        end
      end else if (row_open) begin
        if (pre_ok) nxt = CMD_PRE;          // row miss wins over timeout
      end else if (tz[TI_RP]) begin
        nxt = CMD_ACT;
      end
    end else if (row_open && auto_close && pre_ok) begin
      nxt = CMD_PRE;
    end
  end

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int    ROW_W    = 14,
  parameter int    COL_W    = 10,
  parameter int    TRCD     = 18,
  parameter int    TCL      = 16,
  parameter int    TRP      = 18,
  parameter int    TRAS     = 38,
  parameter int    TWR      = 12,
  parameter int    TWTR     = 8,
  parameter int    IDLE_WIN = 64,
  parameter page_e POLICY   = PAGE_OPEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_valid
);

  localparam int  TMAX    = imax(imax(imax(TRCD, TRP), imax(TRAS, TWR)),
                                 imax(TWTR, imax(IDLE_WIN, 1)));
  localparam int  CW      = $clog2(TMAX + 1);
  localparam bit  IDLE_EN = (IDLE_WIN > 0);
  localparam int  IDLE_LD = IDLE_EN ? IDLE_WIN - 1 : 0;

  // Request holding register
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] prow_q, prow_d;
  logic [COL_W-1:0] pcol_q, pcol_d;
  logic             pwr_q, pwr_d;
  logic             req_en;

  // Bank row state
  logic             open_q, open_d;
  logic             used_q, used_d;
  logic [ROW_W-1:0] orow_q, orow_d;
  logic             bank_en;

  // Registered command outputs
  cmd_e             cmd_q, cmd_d;
  logic [ROW_W-1:0] crow_q, crow_d;
  logic [COL_W-1:0] ccol_q, ccol_d;

  cmd_e             nxt;
  logic             accept;
  logic             access;
  logic [NTMR-1:0]  tz;
  logic [NTMR-1:0]  tld;
  logic [CW-1:0]    tval [NTMR];

  assign req_ready = !pend_q;
  assign accept    = req_valid && req_ready;
  assign access    = (nxt == CMD_RD) || (nxt == CMD_WR);

  dbs_sched #(
    .ROW_W   (ROW_W),
    .POLICY  (POLICY),
    .IDLE_EN (IDLE_EN)
  ) u_sched (
    .pend     (pend_q),
    .pend_row (prow_q),
    .pend_wr  (pwr_q),
    .row_open (open_q),
    .row_used (used_q),
    .open_row (orow_q),
    .tz       (tz),
    .nxt      (nxt)
  );

  // Timer load values and load strobes
  always_comb begin
    tval[TI_RCD]  = CW'(TRCD - 1);
    tval[TI_RP]   = CW'(TRP - 1);
    tval[TI_RAS]  = CW'(TRAS - 1);
    tval[TI_WR]   = CW'(TWR - 1);
    tval[TI_WTR]  = CW'(TWTR - 1);
    tval[TI_IDLE] = CW'(IDLE_LD);
    tld[TI_RCD]   = (nxt == CMD_ACT);
    tld[TI_RAS]   = (nxt == CMD_ACT);
    tld[TI_RP]    = (nxt == CMD_PRE);
    tld[TI_WR]    = (nxt == CMD_WR);
    tld[TI_WTR]   = (nxt == CMD_WR);
    tld[TI_IDLE]  = access;
  end

  generate
    for (genvar gi = 0; gi < NTMR; gi++) begin : g_tmr
      dbs_dcnt #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tld[gi]),
        .value   (tval[gi]),
        .expired (tz[gi])
      );
    end
  endgenerate

  // Next-state logic
  always_comb begin
    req_en = accept || access;
    pend_d = pend_q;
    prow_d = prow_q;
    pcol_d = pcol_q;
    pwr_d  = pwr_q;
    if (accept) begin
      pend_d = 1'b1;
      prow_d = req_row;
      pcol_d = req_col;
      pwr_d  = req_write;
    end else if (access) begin
      pend_d = 1'b0;
    end

    bank_en = (nxt != CMD_NOP);
    open_d  = open_q;
    used_d  = used_q;
    orow_d  = orow_q;
    unique case (nxt)
      CMD_ACT: begin
        open_d = 1'b1;
        used_d = 1'b0;
        orow_d = prow_q;
      end
      CMD_PRE: begin
        open_d = 1'b0;
        used_d = 1'b0;
      end
      CMD_RD, CMD_WR: used_d = 1'b1;
      default: ;
    endcase

    cmd_d  = nxt;
    crow_d = '0;
    ccol_d = '0;
    if (nxt == CMD_PRE)                    crow_d = orow_q;
    else if (nxt != CMD_NOP)               crow_d = prow_q;
    if (access)                            ccol_d = pcol_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prow_q <= '0;
      pcol_q <= '0;
      pwr_q  <= 1'b0;
    end else if (req_en) begin
      pend_q <= pend_d;
      prow_q <= prow_d;
      pcol_q <= pcol_d;
      pwr_q  <= pwr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      used_q <= 1'b0;
      orow_q <= '0;
    end else if (bank_en) begin
      open_q <= open_d;
      used_q <= used_d;
      orow_q <= orow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      crow_q <= '0;
      ccol_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      crow_q <= crow_d;
      ccol_q <= ccol_d;
    end
  end

  assign cmd_valid = (cmd_q != CMD_NOP);
  assign cmd_code  = cmd_q;
  assign cmd_row   = crow_q;
  assign cmd_col   = ccol_q;

  dbs_rdpipe #(.DEPTH(TCL)) u_rdpipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_out   (cmd_q == CMD_RD),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/dbs_sva.sv
// Spacing checker: counts cycles since each command kind at the ports.
module dbs_sva #(
  parameter int TRCD = 18,
  parameter int TRP  = 18,
  parameter int TRAS = 38,
  parameter int TWR  = 12,
  parameter int TWTR = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic [2:0] cmd_code
);

  localparam int SW = 16;
  localparam logic [SW-1:0] SAT = '1;

  logic [SW-1:0] since_act, since_pre, since_wr;
  logic is_act, is_rd, is_wr, is_pre;

  assign is_act = cmd_valid && (cmd_code == 3'd1);
  assign is_rd  = cmd_valid && (cmd_code == 3'd2);
  assign is_wr  = cmd_valid && (cmd_code == 3'd3);
  assign is_pre = cmd_valid && (cmd_code == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
      since_wr  <= SAT;
    end else begin
      since_act <= is_act ? SW'(1) : ((since_act == SAT) ? SAT : since_act + 1'b1);
      since_pre <= is_pre ? SW'(1) : ((since_pre == SAT) ? SAT : since_pre + 1'b1);
      since_wr  <= is_wr  ? SW'(1) : ((since_wr  == SAT) ? SAT : since_wr  + 1'b1);
    end
  end

  a_r1_rcd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || is_wr) |-> (since_act >= SW'(TRCD)));

  a_r3_rp_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= SW'(TRP)));

  a_r4_ras_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_act >= SW'(TRAS)));

  a_r5_wr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (since_wr >= SW'(TWR)));

  a_r5_wtr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> (since_wr >= SW'(TWTR)));

  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code >= 3'd1 && cmd_code <= 3'd4));

endmodule

bind dram_bank_seq dbs_sva #(
  .TRCD (TRCD),
  .TRP  (TRP),
  .TRAS (TRAS),
  .TWR  (TWR),
  .TWTR (TWTR)
) u_dbs_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code)
);

// File: tb/test_dram_bank_seq.sv
module test_dram_bank_seq;
  import dbs_pkg::*;

  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int TRCD  = 3;
  localparam int TCL   = 4;
  localparam int TRP   = 3;
  localparam int TRAS  = 7;
  localparam int TWR   = 5;
  localparam int TWTR  = 3;
  localparam int IDLE  = 6;
  localparam int LOGN  = 1024;

  logic clk;
  logic rst_n;
  logic [1:0] vld, rwr, rdy, cv, rv;
  logic [ROW_W-1:0] rrow [2];
  logic [COL_W-1:0] rcol [2];
  logic [2:0]       cc   [2];
  logic [ROW_W-1:0] cr   [2];
  logic [COL_W-1:0] ccl  [2];

  int cyc, total, bad;
  bit done;

  // observed and predicted command logs
  int o_cyc [2][LOGN]; int o_code [2][LOGN]; int o_row [2][LOGN]; int o_col [2][LOGN];
  int p_cyc [2][LOGN]; int p_code [2][LOGN]; int p_row [2][LOGN]; int p_col [2][LOGN];
  string p_tag [2][LOGN];
  int n_obs [2]; int n_pred [2];
  bit rexp [2][64];

  // model state
  int l_act [2]; int l_pre [2]; int l_wr [2]; int l_acc [2]; int orow [2];
  bit opn [2];

  dram_bank_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .TRCD(TRCD), .TCL(TCL), .TRP(TRP),
    .TRAS(TRAS), .TWR(TWR), .TWTR(TWTR), .IDLE_WIN(IDLE), .POLICY(PAGE_OPEN)
  ) i_dram_bank_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]),
    .req_row(rrow[0]), .req_col(rcol[0]), .req_write(rwr[0]),
    .cmd_valid(cv[0]), .cmd_code(cc[0]), .cmd_row(cr[0]), .cmd_col(ccl[0]),
    .rd_valid(rv[0])
  );

  dram_bank_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .TRCD(TRCD), .TCL(TCL), .TRP(TRP),
    .TRAS(TRAS), .TWR(TWR), .TWTR(TWTR), .IDLE_WIN(IDLE), .POLICY(PAGE_CLOSED)
  ) i_dram_bank_seq_closed (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]),
    .req_row(rrow[1]), .req_col(rcol[1]), .req_write(rwr[1]),
    .cmd_valid(cv[1]), .cmd_code(cc[1]), .cmd_row(cr[1]), .cmd_col(ccl[1]),
    .rd_valid(rv[1])
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: log commands, check read-valid timing and strobe/code agreement
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 2; d++) begin
        if (rv[d] || rexp[d][cyc % 64])
          chk(rv[d] == rexp[d][cyc % 64], "R2 rd_valid", int'(rv[d]), int'(rexp[d][cyc % 64]));
        rexp[d][cyc % 64] = 1'b0;
        if (cv[d] || cc[d] != 3'd0)
          chk(cv[d] == (cc[d] != 3'd0), "R10 strobe vs code", int'(cv[d]), int'(cc[d] != 3'd0));
        if (cv[d]) begin
          if (n_obs[d] < LOGN) begin
            o_cyc[d][n_obs[d]]  = cyc;
            o_code[d][n_obs[d]] = int'(cc[d]);
            o_row[d][n_obs[d]]  = int'(cr[d]);
            o_col[d][n_obs[d]]  = int'(ccl[d]);
          end
          n_obs[d]++;
          if (cc[d] == 3'd2) rexp[d][(cyc + TCL) % 64] = 1'b1;
        end
      end
    end
  end

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic push(input int d, input int t, input int code, input int row,
                      input int col, input string tag);
    if (n_pred[d] < LOGN) begin
      p_cyc[d][n_pred[d]]  = t;
      p_code[d][n_pred[d]] = code;
      p_row[d][n_pred[d]]  = row;
      p_col[d][n_pred[d]]  = col;
      p_tag[d][n_pred[d]]  = tag;
    end
    n_pred[d]++;
  endtask

  // R8: idle-timeout precharge if it falls at or before 'limit'
  task automatic spec_check(input int d, input int limit);
    int t;
    if (d == 0 && opn[d]) begin
      t = mx(l_acc[d] + IDLE, mx(l_act[d] + TRAS, l_wr[d] + TWR));
      if (t <= limit) begin
        push(d, t, 4, orow[d], 0, "R8 idle precharge");
        opn[d] = 1'b0;
        l_pre[d] = t;
      end
    end
  endtask

  task automatic predict(input int d, input int row, input int col, input bit wr, input int acc);
    int a, p, t0;
    string tag;
    spec_check(d, acc + 1);
    if (opn[d] && d == 0 && row == orow[d]) begin
      a = acc + 2; tag = "R6 row hit";
      if (l_act[d] + TRCD > a) begin a = l_act[d] + TRCD; tag = "R1 rcd"; end
      if (!wr && l_wr[d] + TWTR > a) begin a = l_wr[d] + TWTR; tag = "R5 wtr"; end
    end else begin
      if (opn[d]) begin
        p = acc + 2; tag = "R7 miss precharge";
        if (l_act[d] + TRAS > p) begin p = l_act[d] + TRAS; tag = "R4 ras"; end
        if (l_wr[d] + TWR > p)   begin p = l_wr[d] + TWR;   tag = "R5 twr"; end
        push(d, p, 4, orow[d], 0, tag);
        l_pre[d] = p;
        opn[d] = 1'b0;
      end
      t0 = mx(acc + 2, l_pre[d] + TRP);
      tag = (l_pre[d] < 0) ? "R11 first activate" :
            ((l_pre[d] + TRP > acc + 2) ? "R3 rp" : "R7 activate");
      push(d, t0, 1, row, 0, tag);
      l_act[d] = t0;
      opn[d] = 1'b1;
      orow[d] = row;
      a = t0 + TRCD; tag = "R1 rcd";
      if (!wr && l_wr[d] + TWTR > a) begin a = l_wr[d] + TWTR; tag = "R5 wtr"; end
    end
    push(d, a, wr ? 3 : 2, row, col, tag);
    l_acc[d] = a;
    if (wr) l_wr[d] = a;
    if (d == 1) begin
      p = a + 1; tag = "R9 closed precharge";
      if (l_act[d] + TRAS > p) begin p = l_act[d] + TRAS; tag = "R4 ras"; end
      if (l_wr[d] + TWR > p)   begin p = l_wr[d] + TWR;   tag = "R5 twr"; end
      push(d, p, 4, row, 0, tag);
      l_pre[d] = p;
      opn[d] = 1'b0;
    end
  endtask

  // starts and ends at a falling edge
  task automatic send(input int d, input int row, input int col, input bit wr, input int gap);
    int acc;
    repeat (gap) @(negedge clk);
    vld[d] = 1'b1; rrow[d] = ROW_W'(row); rcol[d] = COL_W'(col); rwr[d] = wr;
    while (!rdy[d]) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    vld[d] = 1'b0;
    chk(rdy[d] == 1'b0, "R10 ready low while pending", int'(rdy[d]), 0);
    predict(d, row, col, wr, acc);
  endtask

  task automatic compare(input int d);
    int n;
    n = mx(n_obs[d], n_pred[d]);
    chk(n_obs[d] == n_pred[d], "R10 command count", n_obs[d], n_pred[d]);
    for (int i = 0; i < n && i < LOGN; i++) begin
      if (i >= n_obs[d] || i >= n_pred[d]) break;
      total++;
      if (o_cyc[d][i] != p_cyc[d][i] || o_code[d][i] != p_code[d][i] ||
          o_row[d][i] != p_row[d][i] || o_col[d][i] != p_col[d][i]) begin
        bad++;
        $display("FAIL %s (dut %0d, cmd %0d): actual cyc=%0d code=%0d row=%0d col=%0d expected cyc=%0d code=%0d row=%0d col=%0d",
                 p_tag[d][i], d, i, o_cyc[d][i], o_code[d][i], o_row[d][i], o_col[d][i],
                 p_cyc[d][i], p_code[d][i], p_row[d][i], p_col[d][i]);
      end
    end
  endtask

  task automatic sweep(input int d);
    for (int w1 = 0; w1 < 2; w1++)
      for (int same = 0; same < 2; same++)
        for (int w2 = 0; w2 < 2; w2++)
          for (int gap = 0; gap < 14; gap++) begin
            send(d, 2, gap % 8, w1[0], 0);
            send(d, same ? 2 : 5 + (gap % 3), (gap + 3) % 8, w2[0], gap);
          end
    repeat (40) @(negedge clk);
    spec_check(d, cyc);
  endtask

  initial begin
    rst_n = 1'b0; vld = '0; rwr = '0; done = 1'b0;
    cyc = 0; total = 0; bad = 0;
    for (int d = 0; d < 2; d++) begin
      rrow[d] = '0; rcol[d] = '0;
      n_obs[d] = 0; n_pred[d] = 0;
      l_act[d] = -1000; l_pre[d] = -1000; l_wr[d] = -1000; l_acc[d] = -1000;
      orow[d] = 0; opn[d] = 1'b0;
      for (int k = 0; k < 64; k++) rexp[d][k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk(rdy[d] == 1'b1, "R11 ready after reset", int'(rdy[d]), 1);
      chk(cv[d] == 1'b0, "R11 no command after reset", int'(cv[d]), 0);
      chk(rv[d] == 1'b0, "R11 no rd_valid after reset", int'(rv[d]), 0);
    end
    // directed opening pattern on the open-page bank: read, hit read, write, hit read, miss
    send(0, 3, 1, 1'b0, 0);
    send(0, 3, 2, 1'b0, 0);
    send(0, 3, 4, 1'b1, 0);
    send(0, 3, 5, 1'b0, 0);
    send(0, 9, 6, 1'b1, 0);
    send(0, 9, 7, 1'b0, 0);
    sweep(0);
    compare(0);
    send(1, 4, 1, 1'b0, 0);
    send(1, 4, 2, 1'b1, 0);
    send(1, 4, 3, 1'b0, 0);
    sweep(1);
    compare(1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule